// File: doc/BRIEF.md
# Split dual 8-bit reload timer

This block is a timer built as two independent 8-bit up-counters, a high half and a low half. Each half has its own reload value and its own choice of count rate. When a half counts past 0xFF it loads its reload value and sets a sticky overflow flag. Only software clears that flag, using a one-cycle clear strobe.

Each half selects its rate with its own fast bit. When the fast bit is 1, the half advances on every system clock. When the fast bit is 0, a shared source select chooses one of two tick sources:
- a tick every 12th system clock, from a free-running divider, or
- a tick on every 8th rising edge of an external clock.

The external clock passes through a two-flop synchronizer before its edges are counted. A single level interrupt combines the two flags. The high flag always drives the interrupt. The low flag also drives it when the low-overflow interrupt enable is set.

Top module: `split_tmr`

## Requirements
- R1: While reset is asserted, both counts are 0x00, both flags are 0 and `irq_o` is 0.
- R2: With its fast bit at 1, a half advances its count by one on every system clock.
- R3: With its fast bit at 0 and `ext_sel_i` at 0, a half advances once per 12 system clocks. The tick comes from a divider that runs freely from reset and is shared by both halves.
- R4: With its fast bit at 0 and `ext_sel_i` at 1, a half advances once per 8 rising edges of `ext_clk_i`. Each edge is detected after a two-flop synchronizer, so a half counts on every 8th synchronized edge since reset.
- R5: When a half at count 0xFF receives a tick, its next count is its reload input and its overflow flag becomes 1 in the same cycle.
- R6: The high half counts only while `run_i` is 1; while `run_i` is 0 its count holds. The low half counts regardless of `run_i`.
- R7: A flag stays 1 until its clear strobe is 1 at a clock edge. If an overflow and a clear of the same half coincide, the flag stays 1.
- R8: `irq_o` is 1 exactly when `irq_en_i` is 1 and either the high flag is 1 or both `lo_irq_en_i` and the low flag are 1.
- R9: Each half's fast bit acts only on that half, so the two halves can count at different rates at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | External clock, asynchronous to clk_i |
| run_i | input | 1 | Count enable of the high half |
| hi_fast_i | input | 1 | High half counts every system clock when 1 |
| lo_fast_i | input | 1 | Low half counts every system clock when 1 |
| ext_sel_i | input | 1 | Slow source: 0 gives system clock divided by 12, 1 gives external clock divided by 8 |
| hi_reload_i | input | 8 | High half reload value |
| lo_reload_i | input | 8 | Low half reload value |
| irq_en_i | input | 1 | Interrupt enable |
| lo_irq_en_i | input | 1 | Lets the low flag drive the interrupt |
| hi_flag_clr_i | input | 1 | Clear strobe of the high flag |
| lo_flag_clr_i | input | 1 | Clear strobe of the low flag |
| hi_cnt_o | output | 8 | High half count |
| lo_cnt_o | output | 8 | Low half count |
| hi_flag_o | output | 1 | High half overflow flag |
| lo_flag_o | output | 1 | Low half overflow flag |
| irq_o | output | 1 | Interrupt level |

## Verification
The hardest case to reach from the ports is a clear strobe that lands in exactly the cycle in which the same half overflows. The bench runs the low half at full rate and watches its reference count. At the falling edge where that count reads 0xFF, it raises the low clear strobe for one cycle. It then checks that the flag survives.

The external-divide path is exercised with a slow toggling external clock. Reload values near 0xFF keep overflows within reach. A behavioural model that tracks the synchronizer delay and the shared divide-by-12 phase from reset is compared with every output on every clock.

// File: rtl/split_tmr_pkg.sv
package split_tmr_pkg;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned PRE_DIV = 12;
  localparam int unsigned EXT_DIV = 8;

  typedef enum logic [1:0] {SRC_SYS, SRC_PRE, SRC_EXT} tick_src_e;

  function automatic tick_src_e pick_src(input logic fast, input logic ext_sel);
    if (fast) return SRC_SYS;
    return ext_sel ? SRC_EXT : SRC_PRE;
  endfunction
endpackage

// File: rtl/split_tmr_prescale.sv
module split_tmr_prescale #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [PW-1:0] cnt_q;

  assign tick_o = (cnt_q == PW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/split_tmr_ext_tick.sv
module split_tmr_ext_tick #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  output logic tick_o
);
  localparam int unsigned EW = (DIV > 1) ? $clog2(DIV) : 1;
  logic          s1_q, s2_q, s3_q;
  logic          rise;
  logic [EW-1:0] edge_cnt_q;

  assign rise   = s2_q & ~s3_q;
  assign tick_o = rise & (edge_cnt_q == EW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= ext_clk_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     edge_cnt_q <= '0;
    else if (tick_o) edge_cnt_q <= '0;
    else if (rise)   edge_cnt_q <= edge_cnt_q + EW'(1);
  end
endmodule

// File: rtl/split_tmr_half.sv
module split_tmr_half #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;

  assign cnt_o = cnt_q;
  assign ovf_o = tick_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (ovf_o)  cnt_q <= reload_i;
    else if (tick_i) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/split_tmr.sv
module split_tmr
  import split_tmr_pkg::*;
#(
  parameter int unsigned W     = CNT_W,
  parameter int unsigned P_DIV = PRE_DIV,
  parameter int unsigned X_DIV = EXT_DIV
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ext_clk_i,
  input  logic         run_i,
  input  logic         hi_fast_i,
  input  logic         lo_fast_i,
  input  logic         ext_sel_i,
  input  logic [W-1:0] hi_reload_i,
  input  logic [W-1:0] lo_reload_i,
  input  logic         irq_en_i,
  input  logic         lo_irq_en_i,
  input  logic         hi_flag_clr_i,
  input  logic         lo_flag_clr_i,
  output logic [W-1:0] hi_cnt_o,
  output logic [W-1:0] lo_cnt_o,
  output logic         hi_flag_o,
  output logic         lo_flag_o,
  output logic         irq_o
);
  localparam int unsigned NH = 2;  // index 0 = low, 1 = high

  logic         pre_tick, ext_tick;
  logic [NH-1:0] fast, gate, clr, ovf, flag_q;
  logic [W-1:0]  rl [NH];
  logic [W-1:0]  cnt [NH];

  split_tmr_prescale #(.DIV(P_DIV)) u_pre (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_o(pre_tick)
  );

  split_tmr_ext_tick #(.DIV(X_DIV)) u_ext (
    .clk_i (clk_i), .rst_ni(rst_ni), .ext_clk_i(ext_clk_i), .tick_o(ext_tick)
  );

  assign fast = {hi_fast_i, lo_fast_i};
  assign gate = {run_i, 1'b1};
  assign clr  = {hi_flag_clr_i, lo_flag_clr_i};
  assign rl[0] = lo_reload_i;
  assign rl[1] = hi_reload_i;

  for (genvar i = 0; i < NH; i++) begin : g_half
    tick_src_e src;
    logic      tick;

    assign src = pick_src(fast[i], ext_sel_i);

    always_comb begin
      unique case (src)
        SRC_SYS: tick = 1'b1;
        SRC_PRE: tick = pre_tick;
        SRC_EXT: tick = ext_tick;
        default: tick = 1'b0;
      endcase
      tick = tick & gate[i];
    end

    split_tmr_half #(.W(W)) u_half (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .reload_i(rl[i]),
      .cnt_o   (cnt[i]),
      .ovf_o   (ovf[i])
    );

    // set has priority over a coinciding clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     flag_q[i] <= 1'b0;
      else if (ovf[i]) flag_q[i] <= 1'b1;
      else if (clr[i]) flag_q[i] <= 1'b0;
    end
  end

  assign lo_cnt_o  = cnt[0];
  assign hi_cnt_o  = cnt[1];
  assign lo_flag_o = flag_q[0];
  assign hi_flag_o = flag_q[1];
  assign irq_o     = irq_en_i & (flag_q[1] | (lo_irq_en_i & flag_q[0]));
endmodule

// File: rtl/split_tmr_chk.sv
module split_tmr_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         run_i,
  input logic         hi_fast_i,
  input logic         lo_fast_i,
  input logic [W-1:0] hi_reload_i,
  input logic [W-1:0] lo_reload_i,
  input logic         irq_en_i,
  input logic         lo_irq_en_i,
  input logic         hi_flag_clr_i,
  input logic         lo_flag_clr_i,
  input logic [W-1:0] hi_cnt_o,
  input logic [W-1:0] lo_cnt_o,
  input logic         hi_flag_o,
  input logic         lo_flag_o,
  input logic         irq_o
);
  p_fast_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_fast_i && (lo_cnt_o != '1) |=> lo_cnt_o == $past(lo_cnt_o) + W'(1));

  p_lo_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_fast_i && (lo_cnt_o == '1) |=> (lo_cnt_o == $past(lo_reload_i)) && lo_flag_o);

  p_hi_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && hi_fast_i && (hi_cnt_o == '1) |=> (hi_cnt_o == $past(hi_reload_i)) && hi_flag_o);

  p_hi_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(hi_cnt_o));

  p_hi_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_flag_o && !hi_flag_clr_i |=> hi_flag_o);

  p_lo_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_flag_o && !lo_flag_clr_i |=> lo_flag_o);

  p_irq_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en_i && hi_flag_o |-> irq_o);

  p_irq_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);

  p_irq_lo_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_flag_o && !lo_irq_en_i |-> !irq_o);

  always_comb begin
    if (!rst_ni) begin
      a_reset_r1: assert (hi_cnt_o == '0 && lo_cnt_o == '0 && !hi_flag_o && !lo_flag_o);
    end
  end
endmodule

bind split_tmr split_tmr_chk #(.W(W)) u_chk (.*);

// File: tb/tb_split_tmr.sv
module tb_split_tmr;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0, ext_clk_i = 1'b0;
  logic       run_i = 0, hi_fast_i = 0, lo_fast_i = 0, ext_sel_i = 0;
  logic [7:0] hi_reload_i = 0, lo_reload_i = 0;
  logic       irq_en_i = 0, lo_irq_en_i = 0, hi_flag_clr_i = 0, lo_flag_clr_i = 0;
  logic [7:0] hi_cnt_o, lo_cnt_o;
  logic       hi_flag_o, lo_flag_o, irq_o;

  split_tmr dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit ext_run = 0;
  int ext_div = 0;

  // reference state
  int m_pre, m_edges, m_hi, m_lo;
  bit m_s1, m_s2, m_s3, m_hf, m_lf;

  always @(negedge clk_i) begin
    if (ext_run) begin
      ext_div = ext_div + 1;
      if (ext_div == 3) begin ext_div = 0; ext_clk_i = ~ext_clk_i; end
    end
  end

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pre = 0; m_edges = 0; m_hi = 0; m_lo = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_hf = 0; m_lf = 0;
    end else begin
      bit t12, rise, tx, th, tl, oh, ol;
      t12 = (m_pre == 11);
      m_pre = (m_pre + 1) % 12;
      rise = m_s2 && !m_s3;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk_i;
      tx = rise && (m_edges == 7);
      if (rise) m_edges = (m_edges + 1) % 8;
      th = run_i && (hi_fast_i ? 1'b1 : (ext_sel_i ? tx : t12));
      tl = lo_fast_i ? 1'b1 : (ext_sel_i ? tx : t12);
      oh = th && m_hi == 255;
      ol = tl && m_lo == 255;
      if (oh) m_hi = hi_reload_i; else if (th) m_hi = m_hi + 1;
      if (ol) m_lo = lo_reload_i; else if (tl) m_lo = m_lo + 1;
      if (oh) m_hf = 1; else if (hi_flag_clr_i) m_hf = 0;
      if (ol) m_lf = 1; else if (lo_flag_clr_i) m_lf = 0;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    bit exp_irq;
    exp_irq = irq_en_i && (m_hf || (lo_irq_en_i && m_lf));
    check(req, "hi_cnt", hi_cnt_o, m_hi);
    check(req, "lo_cnt", lo_cnt_o, m_lo);
    check({req, "/R5/R7"}, "hi_flag", hi_flag_o, m_hf);
    check({req, "/R5/R7"}, "lo_flag", lo_flag_o, m_lf);
    check("R8", "irq", irq_o, exp_irq);
  endtask

  task automatic run(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #(CLK_PERIOD/4);
      compare(req);
      @(negedge clk_i);
    end
  endtask

  initial begin
    int held;
    repeat (3) @(negedge clk_i);
    check("R1", "hi_cnt", hi_cnt_o, 0);
    check("R1", "lo_cnt", lo_cnt_o, 0);
    check("R1", "flags", {hi_flag_o, lo_flag_o}, 0);
    check("R1", "irq", irq_o, 0);
    rst_ni = 1;

    // R3: both slow on divide-by-12, high not running yet
    run(60, "R3");

    // R2/R9: both fast, different reloads
    hi_reload_i = 8'hF0; lo_reload_i = 8'h80;
    run_i = 1; hi_fast_i = 1; lo_fast_i = 1; irq_en_i = 1;
    run(600, "R2");
    check("R5", "lo_flag set", lo_flag_o, 1);
    check("R5", "hi_flag set", hi_flag_o, 1);

    // R7: clear both, then R9: low slow while high fast
    hi_flag_clr_i = 1; lo_flag_clr_i = 1;
    run(1, "R7");
    hi_flag_clr_i = 0; lo_flag_clr_i = 0;
    lo_fast_i = 0; lo_reload_i = 8'hF8;
    run(400, "R9");

    // R4: external divide-by-8 on both halves
    ext_run = 1; ext_sel_i = 1; hi_fast_i = 0;
    hi_reload_i = 8'hFC; lo_reload_i = 8'hFE;
    run(3000, "R4");
    check("R4", "lo_flag via ext", lo_flag_o, 1);

    // R6: high half held, low half keeps running
    ext_run = 0; ext_sel_i = 0; lo_fast_i = 1; hi_fast_i = 1; run_i = 0;
    held = hi_cnt_o;
    run(300, "R6");
    check("R6", "hi_cnt held", hi_cnt_o, held);

    // R8: only low flag set, gate with lo_irq_en
    hi_flag_clr_i = 1; run(1, "R8"); hi_flag_clr_i = 0;
    lo_irq_en_i = 0; run(2, "R8");
    check("R8", "irq masked", irq_o, 0);
    lo_irq_en_i = 1; run(2, "R8");
    check("R8", "irq low", irq_o, lo_flag_o);
    irq_en_i = 0; run(2, "R8");
    check("R8", "irq disabled", irq_o, 0);
    irq_en_i = 1;

    // R7: clear coinciding with overflow
    lo_flag_clr_i = 1; run(1, "R7"); lo_flag_clr_i = 0;
    for (int i = 0; i < 400 && m_lo != 255; i++) run(1, "R7");
    check("R7", "lo at FF", lo_cnt_o, 255);
    lo_flag_clr_i = 1;
    run(1, "R7");
    lo_flag_clr_i = 0;
    check("R7", "set wins over clear", lo_flag_o, 1);
    run(50, "R7");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule